// File: doc/BRIEF.md
# Signature-Checked Nibble Substitution Layer

This block applies a 4-bit substitution to every nibble of a 64-bit cipher state. Each of the 16 lanes looks up its nibble in one of two fixed bijective tables. When `load_i` is high, the lane stores the looked-up value in a register. Next to that value it stores a signature predicted for it. While the word sits in the register, each lane recomputes the signature from the nibble it actually drives out and compares it with the stored prediction. Any lane whose two signatures disagree raises the single error output.

A parameter chooses one of two signatures. Single parity adds one bit per lane, so each stored element is 5 bits wide. Interleaved parity adds two bits per lane, so each stored element is 6 bits wide. The interleaved form catches an error in two adjacent bits. Single parity misses such an error.

Two fault masks let a test environment corrupt the path on purpose. One mask XORs onto the data nibbles on their way out. The other XORs onto the stored signatures before they reach the comparison.

Top module: `nsbox_guard`

## Requirements
- R1: While `rst_ni` is low and after reset, with no load and both fault masks at zero, `state_o` is all zeros and `err_o` is 0.
- R2: With `sbox_sel_i`=0, a load stores, for each nibble value x from 0 to F, the entry C,A,D,3,E,B,F,7,8,9,1,5,0,2,4,6 at position x. The stored value appears on the same nibble of `state_o` one clock edge later. Nibble i of the state occupies bits 4i+3:4i.
- R3: With `sbox_sel_i`=1, a load uses the table 1,0,5,3,E,2,F,7,D,A,9,B,C,8,4,6.
- R4: While `load_i` is low, the stored state does not change. With zero masks, `state_o` stays constant.
- R5: When both fault masks are zero, `err_o` is 0 for every stored state.
- R6: `state_o` equals the stored state XOR `data_flip_i`. A single flipped data bit in any lane raises `err_o` in the same cycle.
- R7: A single flipped signature bit raises `err_o` and leaves `state_o` unchanged. In single mode, lane i's signature bit is `sig_flip_i[i]`. In interleaved mode, lane i owns `sig_flip_i[2i+1:2i]`. Bit 2i+1 covers the odd-position data bits 3 and 1, and bit 2i covers the even-position bits 2 and 0.
- R8: In interleaved mode, flipping data bits 1 and 0 of one lane together raises `err_o`. In single-parity mode the same flip leaves `err_o` at 0.
- R9: `err_o` is the OR of all lanes. A fault confined to the lowest lane or to the highest lane raises it on its own.
- R10: When a data flip and a signature flip in the same lane change the recomputed and the stored signature in the same way, the faults mask each other and `err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture the substituted state |
| sbox_sel_i | input | 1 | Table select: 0 or 1 |
| state_i | input | 4*LANES | Input state, nibble i at bits 4i+3:4i |
| data_flip_i | input | 4*LANES | Fault mask XORed onto output nibbles |
| sig_flip_i | input | SIG_W*LANES | Fault mask XORed onto stored signatures |
| state_o | output | 4*LANES | Substituted state after the data mask |
| err_o | output | 1 | OR of all lane mismatch flags |

## Verification
A data fault and a signature fault can hit the same lane in the same cycle. Whether `err_o` rises then depends on whether the two corruptions change the stored and the recomputed signature by the same amount. The bench applies both masks to one lane in a single step: one matching pair that must stay silent, and one mismatched pair that must flag. It also makes a load and a fault mask coincide, so that the freshly captured word is checked with the fault already on it. The expected flag is derived from a behavioural parity model of the stored state.

// File: rtl/nsbox_pkg.sv
package nsbox_pkg;
  typedef enum logic {
    SIG_SINGLE      = 1'b0,
    SIG_INTERLEAVED = 1'b1
  } sig_mode_e;

  localparam int NIB_W = 4;

  function automatic int sig_width(sig_mode_e m);
    return (m == SIG_INTERLEAVED) ? 2 : 1;
  endfunction
endpackage

// File: rtl/nsbox_rom.sv
module nsbox_rom
  import nsbox_pkg::*;
(
  input  logic             sel_i,
  input  logic [NIB_W-1:0] idx_i,
  output logic [NIB_W-1:0] sub_o
);
  logic [NIB_W-1:0] t0, t1;

  always_comb begin
    unique case (idx_i)
      4'h0: t0 = 4'hC; 4'h1: t0 = 4'hA; 4'h2: t0 = 4'hD; 4'h3: t0 = 4'h3;
      4'h4: t0 = 4'hE; 4'h5: t0 = 4'hB; 4'h6: t0 = 4'hF; 4'h7: t0 = 4'h7;
      4'h8: t0 = 4'h8; 4'h9: t0 = 4'h9; 4'hA: t0 = 4'h1; 4'hB: t0 = 4'h5;
      4'hC: t0 = 4'h0; 4'hD: t0 = 4'h2; 4'hE: t0 = 4'h4; default: t0 = 4'h6;
    endcase
    unique case (idx_i)
      4'h0: t1 = 4'h1; 4'h1: t1 = 4'h0; 4'h2: t1 = 4'h5; 4'h3: t1 = 4'h3;
      4'h4: t1 = 4'hE; 4'h5: t1 = 4'h2; 4'h6: t1 = 4'hF; 4'h7: t1 = 4'h7;
      4'h8: t1 = 4'hD; 4'h9: t1 = 4'hA; 4'hA: t1 = 4'h9; 4'hB: t1 = 4'hB;
      4'hC: t1 = 4'hC; 4'hD: t1 = 4'h8; 4'hE: t1 = 4'h4; default: t1 = 4'h6;
    endcase
  end

  assign sub_o = sel_i ? t1 : t0;
endmodule

// File: rtl/nsbox_sig.sv
module nsbox_sig
  import nsbox_pkg::*;
#(
  parameter sig_mode_e MODE  = SIG_INTERLEAVED,
  parameter int        SIG_W = sig_width(MODE)
) (
  input  logic [NIB_W-1:0] d_i,
  output logic [SIG_W-1:0] sig_o
);
  generate
    if (MODE == SIG_INTERLEAVED) begin : g_il
      // [1]: odd positions 3,1  [0]: even positions 2,0
      assign sig_o = {d_i[3] ^ d_i[1], d_i[2] ^ d_i[0]};
    end else begin : g_sp
      assign sig_o = ^d_i;
    end
  endgenerate
endmodule

// File: rtl/nsbox_lane.sv
module nsbox_lane
  import nsbox_pkg::*;
#(
  parameter sig_mode_e MODE  = SIG_INTERLEAVED,
  parameter int        SIG_W = sig_width(MODE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sel_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic [NIB_W-1:0] dflip_i,
  input  logic [SIG_W-1:0] sflip_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             err_o
);
  logic [NIB_W-1:0] sub, dat_q;
  logic [SIG_W-1:0] pred, sig_q, recomp;

  nsbox_rom u_rom (.sel_i(sel_i), .idx_i(nib_i), .sub_o(sub));

  nsbox_sig #(.MODE(MODE), .SIG_W(SIG_W)) u_pred (.d_i(sub), .sig_o(pred));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      sig_q <= '0;
    end else if (load_i) begin
      dat_q <= sub;
      sig_q <= pred;
    end
  end

  assign nib_o = dat_q ^ dflip_i;

  nsbox_sig #(.MODE(MODE), .SIG_W(SIG_W)) u_chk (.d_i(nib_o), .sig_o(recomp));

  assign err_o = (recomp != (sig_q ^ sflip_i));
endmodule

// File: rtl/nsbox_guard.sv
module nsbox_guard
  import nsbox_pkg::*;
#(
  parameter int        LANES = 16,
  parameter sig_mode_e MODE  = SIG_INTERLEAVED,
  parameter int        SIG_W = sig_width(MODE)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic                   sbox_sel_i,
  input  logic [NIB_W*LANES-1:0] state_i,
  input  logic [NIB_W*LANES-1:0] data_flip_i,
  input  logic [SIG_W*LANES-1:0] sig_flip_i,
  output logic [NIB_W*LANES-1:0] state_o,
  output logic                   err_o
);
  logic [LANES-1:0] lane_err;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    nsbox_lane #(.MODE(MODE), .SIG_W(SIG_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .sel_i  (sbox_sel_i),
      .nib_i  (state_i[i*NIB_W +: NIB_W]),
      .dflip_i(data_flip_i[i*NIB_W +: NIB_W]),
      .sflip_i(sig_flip_i[i*SIG_W +: SIG_W]),
      .nib_o  (state_o[i*NIB_W +: NIB_W]),
      .err_o  (lane_err[i])
    );
  end

  assign err_o = |lane_err;
endmodule

// File: rtl/nsbox_guard_chk.sv
module nsbox_guard_chk #(
  parameter int LANES = 16,
  parameter int SIG_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   load_i,
  input logic [4*LANES-1:0]     data_flip_i,
  input logic [SIG_W*LANES-1:0] sig_flip_i,
  input logic [4*LANES-1:0]     state_o,
  input logic                   err_o
);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && data_flip_i == '0) |=> (data_flip_i != '0 || $stable(state_o)));

  a_r5_no_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_flip_i == '0 && sig_flip_i == '0) |-> !err_o);

  a_r6_single_data_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(data_flip_i) == 1 && sig_flip_i == '0) |-> err_o);

  a_r7_single_sig_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_flip_i == '0 && $countones(sig_flip_i) == 1) |-> err_o);
endmodule

bind nsbox_guard nsbox_guard_chk #(.LANES(LANES), .SIG_W(SIG_W)) u_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .data_flip_i(data_flip_i),
  .sig_flip_i (sig_flip_i),
  .state_o    (state_o),
  .err_o      (err_o)
);

// File: tb/nsbox_guard_tb.sv
module nsbox_guard_tb;
  import nsbox_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0, sbox_sel_i = 1'b0;
  logic [63:0] state_i = '0, data_flip_i = '0;
  logic [31:0] sig_flip_il = '0;
  logic [15:0] sig_flip_sp = '0;
  logic [63:0] state_il, state_sp;
  logic err_il, err_sp;

  int checks = 0, errors = 0;
  logic [63:0] model_q = '0;

  always #2.5 clk = ~clk;

  nsbox_guard #(.LANES(16), .MODE(SIG_INTERLEAVED)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .sbox_sel_i(sbox_sel_i),
    .state_i(state_i), .data_flip_i(data_flip_i), .sig_flip_i(sig_flip_il),
    .state_o(state_il), .err_o(err_il));

  nsbox_guard #(.LANES(16), .MODE(SIG_SINGLE)) u_dut_sp (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .sbox_sel_i(sbox_sel_i),
    .state_i(state_i), .data_flip_i(data_flip_i), .sig_flip_i(sig_flip_sp),
    .state_o(state_sp), .err_o(err_sp));

  function automatic logic [3:0] ref_sub(input logic sel, input logic [3:0] x);
    logic [3:0] a [16] = '{4'hC,4'hA,4'hD,4'h3,4'hE,4'hB,4'hF,4'h7,
                           4'h8,4'h9,4'h1,4'h5,4'h0,4'h2,4'h4,4'h6};
    logic [3:0] b [16] = '{4'h1,4'h0,4'h5,4'h3,4'hE,4'h2,4'hF,4'h7,
                           4'hD,4'hA,4'h9,4'hB,4'hC,4'h8,4'h4,4'h6};
    return sel ? b[x] : a[x];
  endfunction

  function automatic logic [1:0] ref_sig(input bit il, input logic [3:0] d);
    logic [1:0] p = '0;
    for (int k = 0; k < 4; k++) begin
      if (!il) p[0] ^= d[k];
      else if (k % 2 == 1) p[1] ^= d[k];
      else p[0] ^= d[k];
    end
    return p;
  endfunction

  function automatic logic exp_err(input bit il, input logic [63:0] df, input logic [31:0] sf);
    logic e = 1'b0;
    for (int l = 0; l < 16; l++) begin
      logic [3:0] d = model_q[l*4 +: 4];
      logic [1:0] pr = ref_sig(il, d) ^ (il ? sf[l*2 +: 2] : {1'b0, sf[l]});
      if (ref_sig(il, d ^ df[l*4 +: 4]) != pr) e = 1'b1;
    end
    return e;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic sl, input logic [63:0] st,
                      input logic [63:0] df, input logic [31:0] sfi,
                      input logic [15:0] sfs, input string tag);
    @(negedge clk);
    load_i = ld; sbox_sel_i = sl; state_i = st;
    data_flip_i = df; sig_flip_il = sfi; sig_flip_sp = sfs;
    @(posedge clk);
    if (ld) for (int l = 0; l < 16; l++) model_q[l*4 +: 4] = ref_sub(sl, st[l*4 +: 4]);
    #1;
    chk(state_il, model_q ^ df, {tag, " state il"});
    chk(state_sp, model_q ^ df, {tag, " state sp"});
    chk({63'd0, err_il}, {63'd0, exp_err(1'b1, df, sfi)}, {tag, " err il"});
    chk({63'd0, err_sp}, {63'd0, exp_err(1'b0, df, {16'd0, sfs})}, {tag, " err sp"});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] lfsr = 64'h0F1E_2D3C_4B5A_6978;
    #7;
    chk(state_il, '0, "R1 reset state");
    chk({63'd0, err_il}, '0, "R1 reset err");
    rst_ni = 1'b1;
    step(0, 0, '0, '0, '0, '0, "R1 idle");
    // R2: identity ramp through table 0, entry 0 -> C
    step(1, 0, 64'hFEDC_BA98_7654_3210, '0, '0, '0, "R2 tab0 ramp");
    chk({60'd0, state_il[3:0]}, 64'hC, "R2 first entry");
    step(0, 1, 64'h1111_1111_1111_1111, '0, '0, '0, "R4 hold");
    step(0, 0, 64'h0, '0, '0, '0, "R4 hold2");
    step(1, 1, 64'hFEDC_BA98_7654_3210, '0, '0, '0, "R3 tab1 ramp");
    step(1, 1, 64'h0123_4567_89AB_CDEF, '0, '0, '0, "R3 tab1 rev");
    for (int n = 0; n < 20; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      step(1, lfsr[7], lfsr, '0, '0, '0, "R5 pattern");
    end
    // R6: every single data bit
    for (int b = 0; b < 64; b++) step(0, 0, '0, 64'd1 << b, '0, '0, "R6 data bit");
    // R7: every single signature bit
    for (int b = 0; b < 32; b++) step(0, 0, '0, '0, 32'd1 << b, '0, "R7 sig il");
    for (int b = 0; b < 16; b++) step(0, 0, '0, '0, '0, 16'd1 << b, "R7 sig sp");
    // R8: adjacent burst on bits 1:0 of lane 5
    step(0, 0, '0, 64'h3 << 20, '0, '0, "R8 burst");
    chk({63'd0, err_il}, 64'd1, "R8 il detects");
    chk({63'd0, err_sp}, 64'd0, "R8 sp misses");
    // R9: lowest and highest lane
    step(0, 0, '0, 64'h1, '0, '0, "R9 lane0");
    step(0, 0, '0, 64'h8 << 60, 32'h0, 16'h0, "R9 lane15");
    step(0, 0, '0, '0, 32'h1 << 31, 16'h1 << 15, "R9 lane15 sig");
    // R10: data bit 0 of lane 3 paired with the matching / mismatched sig bit
    step(0, 0, '0, 64'h1 << 12, 32'h1 << 6, 16'h1 << 3, "R10 cancel");
    chk({63'd0, err_il | err_sp}, 64'd0, "R10 cancel quiet");
    step(0, 0, '0, 64'h1 << 12, 32'h1 << 7, 16'h1 << 4, "R10 mismatch");
    // load and fault in the same cycle
    step(1, 0, 64'h0123_4567_89AB_CDEF, 64'h4 << 36, 32'h1 << 18, 16'h0, "R6 load+fault");
    step(0, 0, '0, '0, '0, '0, "R5 clean after");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule